// File: doc/BRIEF.md
# Partition-Bounded Rotating Comparand Register

This block holds the 64-bit search key used by a content-addressable memory. The key can be loaded from a data bus under a bit mask. Software can also rotate it one position at a time in either direction, so that a pattern can be walked across the key without reloading it.

Each stored word is split into a searchable field and an associated-data field, and the split is chosen at run time by a small partition code. The split falls on 16-bit boundaries. A rotation wraps around the edges of the searchable field rather than the ends of the 64-bit word. Bits that lie in the associated-data field keep their value while a rotation runs. The block only stores and rotates the key; matching against memory is done elsewhere.

Top module: `cmpreg_rotating`

## Requirements
- R1: With `shr_i` high and `load_i` low, every bit in the searchable field moves one place toward bit 0 on the next clock, and the bit at the field's lowest position reappears at the field's highest position.
- R2: With `shl_i` high and both `load_i` and `shr_i` low, every bit in the searchable field moves one place toward bit 63 on the next clock, and the bit at the field's highest position reappears at the field's lowest position.
- R3: The partition code sets the searchable field as follows. `part_code_i[1:0]` gives the number N (0 to 3) of 16-bit segments given to associated data. If `part_code_i[2]` is 0, those segments sit at the low end and the searchable field is bits 63 down to 16·N. If `part_code_i[2]` is 1, they sit at the high end and the searchable field is bits 63−16·N down to 0.
- R4: With `load_i` high, each register bit whose `load_mask_i` bit is 0 takes the matching `load_data_i` bit on the next clock. Each bit whose mask bit is 1 keeps its value.
- R5: A rotation leaves every bit outside the searchable field unchanged.
- R6: Priority is load first, then shift-right, then shift-left. When no strobe is high, the register holds its value.
- R7: While `rst_n` is low at a rising clock edge, the register clears to all zeros. This holds even if strobes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe |
| load_data_i | input | 64 | Data to load |
| load_mask_i | input | 64 | Load mask; 1 protects a bit |
| shr_i | input | 1 | Rotate one bit toward bit 0 |
| shl_i | input | 1 | Rotate one bit toward bit 63 |
| part_code_i | input | 3 | Partition code (see R3) |
| value_o | output | 64 | Current register contents |

## Verification
A single set bit is placed at the lowest position of the searchable field and rotated right, then back left, under all eight partition codes. This tells a correct wrap point apart from wrapping at the word end or at a wrong 16-bit boundary. Dense pseudo-random words, rotated many times in a row, reveal any leakage into the associated-data bits and any lost or duplicated bit. Masked loads with alternating mask patterns separate protected bits from written ones. Strobes applied together, or none at all, confirm the priority order and the hold behaviour.

// File: rtl/cmpreg_pkg.sv
// Package: shared types for the rotating comparand register.
// Assumes: nothing; only holds the operation selector used by the top.
package cmpreg_pkg;

    // Operation applied to the register on the next clock edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_SHR  = 2'd2,
        OP_SHL  = 2'd3
    } cmp_op_e;

endpackage

// File: rtl/cmpreg_field_decode.sv
// Module: cmpreg_field_decode
// Turns the partition code into the searchable-field limits and a per-bit
// field mask (1 = searchable). Assumes WIDTH is a multiple of SEG and that
// the segment count is a power of two. The top code bit places the data
// segments at the MSB side; the low bits count them.
module cmpreg_field_decode #(
    parameter int WIDTH = 64,
    parameter int SEG   = 16
) (
    input  logic [$clog2(WIDTH/SEG):0]   code_i,
    output logic [$clog2(WIDTH)-1:0]     lo_o,
    output logic [$clog2(WIDTH)-1:0]     hi_o,
    output logic [WIDTH-1:0]             cam_mask_o
);
    localparam int NSEG  = WIDTH / SEG;
    localparam int SEGW  = $clog2(NSEG);
    localparam int IDX_W = $clog2(WIDTH);

    // Compute the lowest and highest searchable bit positions
    always_comb begin
        int ram_bits;
        ram_bits = int'(code_i[SEGW-1:0]) * SEG;
        if (code_i[SEGW]) begin
            lo_o = '0;
            hi_o = IDX_W'(WIDTH - 1 - ram_bits);
        end else begin
            lo_o = IDX_W'(ram_bits);
            hi_o = IDX_W'(WIDTH - 1);
        end
    end

    // One comparator pair per bit builds the field mask
    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        assign cam_mask_o[i] = (IDX_W'(i) >= lo_o) && (IDX_W'(i) <= hi_o);
    end

endmodule

// File: rtl/cmpreg_rotator.sv
// Module: cmpreg_rotator
// Rotates a word by one bit inside the field [lo_i, hi_i]. Bits outside
// the field pass through unchanged. LEFT selects the direction: 1 moves
// toward the MSB. Assumes lo_i <= hi_i and that cam_i marks exactly that range.
module cmpreg_rotator #(
    parameter int WIDTH = 64,
    parameter bit LEFT  = 1'b0
) (
    input  logic [WIDTH-1:0]          val_i,
    input  logic [WIDTH-1:0]          cam_i,
    input  logic [$clog2(WIDTH)-1:0]  lo_i,
    input  logic [$clog2(WIDTH)-1:0]  hi_i,
    output logic [WIDTH-1:0]          val_o
);
    localparam int IDX_W = $clog2(WIDTH);

    logic wrap_bit;
    logic [IDX_W-1:0] entry_idx;

    // Pick the bit that leaves the field and the position where it reenters
    always_comb begin
        if (LEFT) begin
            wrap_bit  = val_i[hi_i];
            entry_idx = lo_i;
        end else begin
            wrap_bit  = val_i[lo_i];
            entry_idx = hi_i;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic neighbour;
        if (LEFT) begin : g_left
            if (i == 0) begin : g_edge
                assign neighbour = val_i[i];
            end else begin : g_mid
                assign neighbour = val_i[i-1];
            end
        end else begin : g_right
            if (i == WIDTH - 1) begin : g_edge
                assign neighbour = val_i[i];
            end else begin : g_mid
                assign neighbour = val_i[i+1];
            end
        end
        // Field bits take the neighbour or the wrapped bit; others hold
        assign val_o[i] = !cam_i[i]                  ? val_i[i]  :
                          (IDX_W'(i) == entry_idx)   ? wrap_bit  :
                                                       neighbour;
    end

endmodule

// File: rtl/cmpreg_load_merge.sv
// Module: cmpreg_load_merge
// Merges new data into the current word under a mask: a 0 mask bit takes
// the new bit, a 1 mask bit keeps the old one. Purely combinational.
module cmpreg_load_merge #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] old_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic [WIDTH-1:0] val_o
);
    // Bitwise select between retained and written bits
    always_comb begin
        val_o = (old_i & mask_i) | (data_i & ~mask_i);
    end

endmodule

// File: rtl/cmpreg_rotating.sv
// Module: cmpreg_rotating (top)
// Comparand register with masked load and one-bit rotation bounded by the
// searchable field chosen by the partition code. Load beats shift-right,
// which beats shift-left. Synchronous active-low reset clears it to zero.
// Assumes the partition code is stable in any cycle where a shift is issued.
module cmpreg_rotating #(
    parameter int WIDTH = 64,
    parameter int SEG   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [WIDTH-1:0]             load_data_i,
    input  logic [WIDTH-1:0]             load_mask_i,
    input  logic                         shr_i,
    input  logic                         shl_i,
    input  logic [$clog2(WIDTH/SEG):0]   part_code_i,
    output logic [WIDTH-1:0]             value_o
);
    import cmpreg_pkg::*;

    localparam int IDX_W = $clog2(WIDTH);

    logic [WIDTH-1:0] cmp_q;
    logic [WIDTH-1:0] cmp_d;
    logic [WIDTH-1:0] cam_mask;
    logic [IDX_W-1:0] cam_lo;
    logic [IDX_W-1:0] cam_hi;
    logic [WIDTH-1:0] rot_right;
    logic [WIDTH-1:0] rot_left;
    logic [WIDTH-1:0] loaded;
    cmp_op_e          op;

    cmpreg_field_decode #(.WIDTH(WIDTH), .SEG(SEG)) i_decode (
        .code_i     (part_code_i),
        .lo_o       (cam_lo),
        .hi_o       (cam_hi),
        .cam_mask_o (cam_mask)
    );

    cmpreg_rotator #(.WIDTH(WIDTH), .LEFT(1'b0)) i_rot_right (
        .val_i (cmp_q),
        .cam_i (cam_mask),
        .lo_i  (cam_lo),
        .hi_i  (cam_hi),
        .val_o (rot_right)
    );

    cmpreg_rotator #(.WIDTH(WIDTH), .LEFT(1'b1)) i_rot_left (
        .val_i (cmp_q),
        .cam_i (cam_mask),
        .lo_i  (cam_lo),
        .hi_i  (cam_hi),
        .val_o (rot_left)
    );

    cmpreg_load_merge #(.WIDTH(WIDTH)) i_merge (
        .old_i  (cmp_q),
        .data_i (load_data_i),
        .mask_i (load_mask_i),
        .val_o  (loaded)
    );

    // Resolve strobes into one operation by fixed priority
    always_comb begin
        if (load_i)      op = OP_LOAD;
        else if (shr_i)  op = OP_SHR;
        else if (shl_i)  op = OP_SHL;
        else             op = OP_HOLD;
    end

    // Select the next register value for the chosen operation
    always_comb begin
        unique case (op)
            OP_LOAD: cmp_d = loaded;
            OP_SHR:  cmp_d = rot_right;
            OP_SHL:  cmp_d = rot_left;
            default: cmp_d = cmp_q;
        endcase
    end

    // Register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign value_o = cmp_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> value_o == '0); // R7

    AST_SHR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && shr_i) |=> value_o[$past(cam_hi)] == $past(value_o[cam_lo])); // R1

    AST_SHL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shr_i && shl_i) |=> value_o[$past(cam_lo)] == $past(value_o[cam_hi])); // R2

    AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (shr_i || shl_i)) |=>
        $countones(value_o & $past(cam_mask)) == $countones($past(value_o & cam_mask))); // R1

    AST_DATA_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (shr_i || shl_i)) |=>
        (value_o & ~$past(cam_mask)) == ($past(value_o) & ~$past(cam_mask))); // R5

    AST_MASK_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (value_o & $past(load_mask_i)) == ($past(value_o) & $past(load_mask_i))); // R4

    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (value_o & ~$past(load_mask_i)) == ($past(load_data_i) & ~$past(load_mask_i))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shr_i && !shl_i) |=> $stable(value_o)); // R6

endmodule

// File: tb/test_cmpreg_rotating.sv
// Scoreboard bench: the driver task applies one operation per cycle and
// queues the expected value; the monitor pops and compares after each edge.
module test_cmpreg_rotating;

    localparam int W = 64;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] load_data_i = '0;
    logic [W-1:0] load_mask_i = '0;
    logic         shr_i = 1'b0;
    logic         shl_i = 1'b0;
    logic [2:0]   part_code_i = '0;
    logic [W-1:0] value_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];
    logic [W-1:0] model = '0;

    always #2 clk = ~clk;

    cmpreg_rotating i_cmpreg_rotating (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_data_i (load_data_i),
        .load_mask_i (load_mask_i),
        .shr_i       (shr_i),
        .shl_i       (shl_i),
        .part_code_i (part_code_i),
        .value_o     (value_o)
    );

    // Field limits from the partition code as stated in R3
    function automatic int f_lo(input logic [2:0] c);
        return c[2] ? 0 : 16 * int'(c[1:0]);
    endfunction
    function automatic int f_hi(input logic [2:0] c);
        return c[2] ? 63 - 16 * int'(c[1:0]) : 63;
    endfunction

    function automatic logic [W-1:0] m_shr(input logic [W-1:0] v, input logic [2:0] c);
        logic [W-1:0] t = v;
        int lo = f_lo(c);
        int hi = f_hi(c);
        for (int i = lo; i < hi; i++) t[i] = v[i+1];
        t[hi] = v[lo];
        return t;
    endfunction

    function automatic logic [W-1:0] m_shl(input logic [W-1:0] v, input logic [2:0] c);
        logic [W-1:0] t = v;
        int lo = f_lo(c);
        int hi = f_hi(c);
        for (int i = lo + 1; i <= hi; i++) t[i] = v[i-1];
        t[lo] = v[hi];
        return t;
    endfunction

    // Driver: apply one operation and queue the expected result
    task automatic drive(input bit ld, input logic [W-1:0] d, input logic [W-1:0] m,
                         input bit r, input bit l, input logic [2:0] c, input string tag);
        item_t it;
        @(negedge clk);
        load_i = ld; load_data_i = d; load_mask_i = m;
        shr_i = r; shl_i = l; part_code_i = c;
        if (ld)     model = (model & m) | (d & ~m);
        else if (r) model = m_shr(model, c);
        else if (l) model = m_shl(model, c);
        it.exp = model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare one queued item after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (value_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, value_o, it.exp);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [W-1:0] rv;
        logic [W-1:0] onehot;
        // R7: reset dominates an active load
        load_i = 1'b1; load_data_i = '1; load_mask_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (value_o !== '0) begin
            n_fail++;
            $display("FAIL R7: got %h expected %h", value_o, 64'h0);
        end
        rst_n = 1'b1;
        load_i = 1'b0;
        model = '0;

        // R4: unmasked and masked loads
        drive(1, '1, '0, 0, 0, 3'd0, "R4");
        drive(1, '0, 64'hFFFF_0000_FFFF_0000, 0, 0, 3'd0, "R4");
        drive(1, 64'h0123_4567_89AB_CDEF, 64'hAAAA_AAAA_5555_5555, 0, 0, 3'd0, "R4");

        // R1 R2 R3: single bit at field bottom, rotate right then back left
        for (int c = 0; c < 8; c++) begin
            onehot = '0;
            onehot[f_lo(3'(c))] = 1'b1;
            drive(1, onehot | ~(~64'h0 >> 0 & 64'h0) & 64'h0, '0, 0, 0, 3'(c), "R3");
            drive(0, '0, '0, 1, 0, 3'(c), "R1 R3");
            drive(0, '0, '0, 0, 1, 3'(c), "R2 R3");
            drive(0, '0, '0, 0, 1, 3'(c), "R2 R3");
            drive(0, '0, '0, 1, 0, 3'(c), "R1 R3");
        end

        // R5 R1 R2: dense random words rotated repeatedly under every code
        for (int c = 0; c < 8; c++) begin
            rv = {$urandom(c + 11), $urandom()};
            drive(1, rv, '0, 0, 0, 3'(c), "R4");
            for (int k = 0; k < 20; k++) drive(0, '0, '0, 1, 0, 3'(c), "R1 R5");
            for (int k = 0; k < 37; k++) drive(0, '0, '0, 0, 1, 3'(c), "R2 R5");
        end

        // R6: priority and hold
        rv = 64'hDEAD_BEEF_0BAD_F00D;
        drive(1, rv, '0, 0, 0, 3'd1, "R4");
        drive(1, 64'h5A5A_5A5A_5A5A_5A5A, '0, 1, 1, 3'd1, "R6");
        drive(0, '0, '0, 1, 1, 3'd1, "R6");
        drive(0, '0, '0, 1, 1, 3'd6, "R6");
        drive(0, '0, '0, 0, 0, 3'd6, "R6");
        drive(0, '1, '0, 0, 0, 3'd2, "R6");

        // R7: reset again mid-run
        @(negedge clk);
        load_i = 1'b0; shr_i = 1'b0; shl_i = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        n_checks++;
        if (value_o !== '0) begin
            n_fail++;
            $display("FAIL R7: got %h expected %h", value_o, 64'h0);
        end
        shl_i = 1'b0;
        repeat (3) @(posedge clk);
        summary();
    end

endmodule